// File: doc/BRIEF.md
# Grouped Error Interrupt Status Controller

This block gathers the error conditions and device interrupt lines of a bus bridge into one 32-bit status word. Other logic detects the errors and sends each one in as a single-cycle pulse. The block records it in a bit that stays set. A 32-bit enable word selects which status bits drive the host interrupt. A separate fatal output summarises the errors that the system cannot recover from. Eight device interrupt lines are sampled into the low byte of the status word. A mapping register gives each line a 3-bit device number.

Error bits are cleared in groups. A write to the clear register names one or more groups, and every status bit in a selected group drops. Bit 31 is a sticky multiple-error flag. It records that a new error arrived while an enabled error was already pending, and only its own group bit clears it. Software reaches the status, enable, clear, mode and mapping registers through a plain select/write-enable port. Reads are combinational. No data is streamed through this block, so every pin is a plain control or status signal.

Top module: `err_irq_collector`

## Requirements
- R1: While reset is held and after it is released, status, enable, mode and mapping read as zero, and host_irq and fatal_err are low.
- R2: A high bit i of err_evt (i = 0..22) sets status bit i+8 at the next clock edge. The bit then stays set until its group is cleared.
- R3: Status bits 7..0 show the level of dev_line sampled at the previous clock edge.
- R4: A write to select 2 clears, at that edge, the status bits of each group whose select bit is set. Bit 0 clears bits 15..8. Bit 1 clears bits 30 and 16. Bit 2 clears bits 21..17. Bit 3 clears bits 27, 25, 24 and 23.
- R5: For the same write, bit 4 clears bits 28, 26 and 9, bit 5 clears bits 29 and 22, and bit 6 clears bit 31. Writing 0x7F clears bits 31..8, and data bits 31..7 of the write have no effect.
- R6: If an error event and a clear of its group come in the same cycle, the status bit ends up set.
- R7: Bit 31 is set when any err_evt bit is high while any status bit in 30..8 is set with its enable bit set. It is cleared only by clear bit 6, and a set in the same cycle wins.
- R8: host_irq is high exactly when some status bit and the enable bit at the same position are both set.
- R9: fatal_err is high exactly when any of status bits 29..22, 14 or 13 is set.
- R10: A write to select 4 loads the mapping register from wdata[23:0]. Line n's device number sits at bits 3n+2..3n of dev_map and of the read data.
- R11: Select codes are: 0 status (read-only, writes ignored), 1 enable (32 bits), 2 clear (write-only, reads zero), 3 mode (8 bits, read back zero-extended), 4 mapping. Codes 5..7 read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 23 | Error event pulses, bit i goes to status bit i+8 |
| dev_line | input | 8 | Device interrupt line levels |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| host_irq | output | 1 | Host interrupt request |
| fatal_err | output | 1 | Fatal error summary |
| dev_map | output | 24 | Device number per interrupt line |

## Verification
The bench builds the block with its default 3-bit device number, which gives a 24-bit mapping word. With that setting every one of the eight line fields, each of the seven clear groups, and the full 32-bit status layout can be driven and read back through the port. Random sparse error pulses, mixed with random register writes, create overlaps of set and clear and of multiple errors. Directed sequences then pin down the multiple-error flag and the fatal set bit by bit.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int STAT_W   = 32;
  localparam int LINES    = 8;
  localparam int ERR_LSB  = LINES;
  localparam int ERR_N    = 23;
  localparam int MULTI_BIT = 31;
  localparam int GROUPS   = 7;
  localparam int SEL_W    = 3;

  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ENABLE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CLEAR  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MAP    = 3'd4;

  // clear groups, index = select bit of the clear register
  localparam logic [GROUPS-1:0][STAT_W-1:0] GRP_MASK = {
    32'h8000_0000,   // 6: multiple-error flag
    32'h2040_0000,   // 5: unexpected response, request queue overflow
    32'h1400_0200,   // 4: response path errors, read timeout
    32'h0B80_0000,   // 3: request dispatch errors
    32'h003E_0000,   // 2: link errors
    32'h4001_0000,   // 1: table RAM parity, entry size fault
    32'h0000_FF00    // 0: downstream bus errors
  };

  localparam logic [STAT_W-1:0] FATAL_MASK = 32'h3FC0_6000;
endpackage

// File: rtl/err_status_bank.sv
module err_status_bank
  import err_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_N-1:0]  err_evt,
  input  logic [GROUPS-1:0] clr_grp,
  input  logic [ERR_N-1:0]  err_en,
  output logic [ERR_N-1:0]  err_bits,
  output logic              multi_err
);
  localparam int HI_W = STAT_W - ERR_LSB;

  logic [GROUPS-1:0][HI_W-1:0] grp_vec;
  logic [HI_W-1:0]             clr_vec;
  logic                        any_evt;
  logic                        pend_en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_vec[g] = clr_grp[g] ? GRP_MASK[g][STAT_W-1:ERR_LSB] : '0;
  end

  always_comb begin
    clr_vec = '0;
    for (int g = 0; g < GROUPS; g++) clr_vec = clr_vec | grp_vec[g];
  end

  assign any_evt = |err_evt;
  assign pend_en = |(err_bits & err_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_bits  <= '0;
      multi_err <= 1'b0;
    end else begin
      err_bits  <= (err_bits & ~clr_vec[ERR_N-1:0]) | err_evt;
      multi_err <= (multi_err & ~clr_vec[HI_W-1]) | (any_evt & pend_en);
    end
  end
endmodule

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] line_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_in;
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import err_irq_pkg::*;
#(
  parameter int MAP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] enable_q,
  output logic [MAP_W-1:0]  map_q,
  output logic [GROUPS-1:0] clr_grp,
  output logic [STAT_W-1:0] rdata
);
  logic [7:0] mode_q;

  assign clr_grp = (we && sel == SEL_CLEAR) ? wdata[GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      mode_q   <= '0;
      map_q    <= '0;
    end else if (we) begin
      case (sel)
        SEL_ENABLE: enable_q <= wdata;
        SEL_MODE:   mode_q   <= wdata[7:0];
        SEL_MAP:    map_q    <= wdata[MAP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS: rdata = status;
      SEL_ENABLE: rdata = enable_q;
      SEL_MODE:   rdata = {{(STAT_W-8){1'b0}}, mode_q};
      SEL_MAP:    rdata = {{(STAT_W-MAP_W){1'b0}}, map_q};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_irq_collector.sv
module err_irq_collector
  import err_irq_pkg::*;
#(
  parameter int DEV_W = 3,
  localparam int MAP_W = LINES * DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_N-1:0]  err_evt,
  input  logic [LINES-1:0]  dev_line,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              host_irq,
  output logic              fatal_err,
  output logic [MAP_W-1:0]  dev_map
);
  logic [ERR_N-1:0]  err_bits;
  logic              multi_err;
  logic [LINES-1:0]  line_q;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] enable_q;
  logic [GROUPS-1:0] clr_grp;

  err_status_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt   (err_evt),
    .clr_grp   (clr_grp),
    .err_en    (enable_q[MULTI_BIT-1:ERR_LSB]),
    .err_bits  (err_bits),
    .multi_err (multi_err)
  );

  line_sampler #(.N(LINES)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (dev_line),
    .line_q  (line_q)
  );

  assign status_q = {multi_err, err_bits, line_q};

  irq_reg_bank #(.MAP_W(MAP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .status   (status_q),
    .enable_q (enable_q),
    .map_q    (dev_map),
    .clr_grp  (clr_grp),
    .rdata    (reg_rdata)
  );

  assign host_irq  = |(status_q & enable_q);
  assign fatal_err = |(status_q & FATAL_MASK);
endmodule

// File: rtl/err_irq_collector_chk.sv
module err_irq_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [22:0] err_evt,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [23:0] reg_wdata,
  input logic [23:0] err_hi,
  input logic [31:0] enable,
  input logic        host_irq,
  input logic        fatal_err,
  input logic [23:0] dev_map
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_hi[22:0] & $past(err_evt)) == $past(err_evt)));

  assert_link_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd2 && reg_wdata[2] && err_evt == '0) |=> (err_hi[13:9] == '0));

  assert_multi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hi[23] && !(reg_we && reg_sel == 3'd2 && reg_wdata[6])) |=> err_hi[23]);

  assert_no_enable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !host_irq);

  assert_fatal_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fatal_err && err_evt == '0) |=> !fatal_err);

  assert_map_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd4) |=> (dev_map == $past(reg_wdata)));
endmodule

bind err_irq_collector err_irq_collector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt   (err_evt),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata[23:0]),
  .err_hi    (status_q[31:8]),
  .enable    (enable_q),
  .host_irq  (host_irq),
  .fatal_err (fatal_err),
  .dev_map   (dev_map)
);

// File: tb/err_irq_collector_bench.sv
module err_irq_collector_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] err_evt = '0;
  logic [7:0]  dev_line = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq, fatal_err;
  logic [23:0] dev_map;

  int tests = 0;
  int fails = 0;

  // bench model
  logic [31:0] m_st = '0, m_en = '0;
  logic [7:0]  m_mode = '0;
  logic [23:0] m_map = '0;

  err_irq_collector u_err_irq_collector (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .dev_line(dev_line),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq), .fatal_err(fatal_err),
    .dev_map(dev_map)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] grp_bits(input logic [6:0] g);
    logic [31:0] m = '0;
    if (g[0]) m |= 32'h0000_FF00;
    if (g[1]) m |= 32'h4001_0000;
    if (g[2]) m |= 32'h003E_0000;
    if (g[3]) m |= 32'h0B80_0000;
    if (g[4]) m |= 32'h1400_0200;
    if (g[5]) m |= 32'h2040_0000;
    if (g[6]) m |= 32'h8000_0000;
    return m;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return m_st;
      3'd1: return m_en;
      3'd3: return {24'h0, m_mode};
      3'd4: return {8'h0, m_map};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock cycle with given inputs; model advances; outputs checked
  task automatic cyc(input logic [22:0] evt, input logic [7:0] ln, input logic we,
                     input logic [2:0] sel, input logic [31:0] wd, input string tag);
    logic [31:0] clr, nst;
    @(negedge clk);
    err_evt = evt; dev_line = ln; reg_we = we; reg_sel = sel; reg_wdata = wd;
    clr = (we && sel == 3'd2) ? grp_bits(wd[6:0]) : 32'h0;
    nst[7:0]   = ln;
    nst[30:8]  = (m_st[30:8] & ~clr[30:8]) | evt;
    nst[31]    = (m_st[31] & ~clr[31]) | ((|evt) & (|(m_st[30:8] & m_en[30:8])));
    @(posedge clk);
    m_st = nst;
    if (we && sel == 3'd1) m_en = wd;
    if (we && sel == 3'd3) m_mode = wd[7:0];
    if (we && sel == 3'd4) m_map = wd[23:0];
    #(CLK_PERIOD/4);
    chk({tag, " R8 host_irq"}, {31'h0, host_irq}, {31'h0, |(m_st & m_en)});
    chk({tag, " R9 fatal_err"}, {31'h0, fatal_err}, {31'h0, |(m_st & 32'h3FC0_6000)});
    chk({tag, " R11 rdata"}, reg_rdata, exp_read(sel));
    chk({tag, " R10 dev_map"}, {8'h0, dev_map}, {8'h0, m_map});
  endtask

  task automatic idle(input logic [2:0] sel, input string tag);
    cyc(23'h0, dev_line, 1'b0, sel, 32'h0, tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] wd, input string tag);
    cyc(23'h0, dev_line, 1'b1, sel, wd, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    #1;
    chk("R1 irq in reset", {31'h0, host_irq}, 32'h0);
    chk("R1 fatal in reset", {31'h0, fatal_err}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < 5; s++) idle(3'(s), "R1 post-reset read");
    chk("R1 status zero", reg_rdata, 32'h0);

    // R2 set and sticky
    wr(3'd1, 32'hFFFF_FFFF, "R2 enable all");
    cyc(23'h000001, 8'h00, 1'b0, 3'd0, 32'h0, "R2 set");
    idle(3'd0, "R2 hold"); idle(3'd0, "R2 hold");
    chk("R2 bit8 sticky", reg_rdata & 32'h100, 32'h100);

    // R3 device lines
    cyc(23'h0, 8'hA5, 1'b0, 3'd0, 32'h0, "R3 lines");
    chk("R3 low byte", {24'h0, reg_rdata[7:0]}, 32'hA5);
    cyc(23'h0, 8'h00, 1'b0, 3'd0, 32'h0, "R3 lines off");

    // R4/R5 per-group clear
    for (int g = 0; g < 7; g++) begin
      cyc(23'h7FFFFF, 8'h00, 1'b0, 3'd0, 32'h0, "R4 fill");
      idle(3'd0, "R4 fill2");
      wr(3'd2, 32'h1 << g, (g < 4) ? "R4 group clear" : "R5 group clear");
      idle(3'd0, "R5 after clear");
      chk((g < 4) ? "R4 group bits" : "R5 group bits", reg_rdata & grp_bits(7'(1 << g)), 32'h0);
    end
    cyc(23'h7FFFFF, 8'h00, 1'b0, 3'd0, 32'h0, "R5 fill");
    idle(3'd0, "R5 fill2");
    wr(3'd2, 32'hFFFF_FF7F, "R5 clear all");
    idle(3'd0, "R5 read");
    chk("R5 all cleared", reg_rdata, 32'h0);

    // R6 set wins
    cyc(23'h000002, 8'h00, 1'b1, 3'd2, 32'h10, "R6 same cycle");
    idle(3'd0, "R6 read");
    chk("R6 bit9 kept", reg_rdata & 32'h200, 32'h200);
    wr(3'd2, 32'h7F, "R6 cleanup");

    // R7 multiple error
    wr(3'd1, 32'h0, "R7 enable none");
    cyc(23'h000001, 8'h00, 1'b0, 3'd0, 32'h0, "R7 first");
    cyc(23'h000002, 8'h00, 1'b0, 3'd0, 32'h0, "R7 second masked");
    chk("R7 no multi when masked", reg_rdata & 32'h8000_0000, 32'h0);
    wr(3'd1, 32'h0000_0100, "R7 enable bit8");
    cyc(23'h000004, 8'h00, 1'b0, 3'd0, 32'h0, "R7 third");
    chk("R7 multi set", reg_rdata & 32'h8000_0000, 32'h8000_0000);
    wr(3'd2, 32'h3F, "R7 clear others");
    idle(3'd0, "R7 read");
    chk("R7 multi survives", reg_rdata & 32'h8000_0000, 32'h8000_0000);
    wr(3'd2, 32'h40, "R7 clear multi");
    idle(3'd0, "R7 read2");
    chk("R7 multi cleared", reg_rdata, 32'h0);

    // R9 fatal set selection
    cyc(23'h000002, 8'h00, 1'b0, 3'd0, 32'h0, "R9 timeout only");
    chk("R9 timeout not fatal", {31'h0, fatal_err}, 32'h0);
    cyc(23'h000020, 8'h00, 1'b0, 3'd0, 32'h0, "R9 serr");
    chk("R9 serr fatal", {31'h0, fatal_err}, 32'h1);
    wr(3'd2, 32'h7F, "R9 cleanup");

    // R10 mapping fields
    wr(3'd4, 32'hFFFA_C688, "R10 map write");
    chk("R10 line5 field", {29'h0, dev_map[17:15]}, {29'h0, m_map[17:15]});
    chk("R10 line0 field", {29'h0, dev_map[2:0]}, 32'h0);

    // R11 select behaviour
    cyc(23'h0, 8'h3C, 1'b0, 3'd0, 32'h0, "R11 prep");
    wr(3'd0, 32'hFFFF_FFFF, "R11 status write ignored");
    chk("R11 status unchanged", reg_rdata, 32'h0000_003C);
    wr(3'd3, 32'h1234_56C3, "R11 mode write");
    chk("R11 mode readback", reg_rdata, 32'h0000_00C3);
    wr(3'd7, 32'hFFFF_FFFF, "R11 code 7 write");
    chk("R11 code 7 reads zero", reg_rdata, 32'h0);
    idle(3'd2, "R11 clear reads zero");
    chk("R11 clear reads zero", reg_rdata, 32'h0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [22:0] ev;
      logic        w;
      ev = 23'($urandom) & 23'($urandom) & 23'($urandom) & 23'($urandom);
      w  = ($urandom % 4) == 0;
      cyc(ev, 8'($urandom), w, 3'($urandom), $urandom, "R2 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule